// File: doc/BRIEF.md
# Legacy Memory Window Router

This block owns the few configuration bytes that decide where processor accesses into the legacy upper-memory window (0xA0000 to 0xFFFFF) are sent. For each access it looks at the address, the direction and whether the processor is in system management mode. It then answers with one of three routes: main DRAM, the downstream expansion bus, or a "not legacy" pass-through for addresses outside the window. A write-suppress flag goes with the DRAM route for segments that are marked read-only.

The window has three kinds of region. The graphics hole from 0xA0000 to 0xBFFFF is opened to DRAM by a control byte. Its open bit works in every mode, and a second bit opens it only for accesses made in system management mode. The option ROM area from 0xC0000 to 0xEFFFF is cut into twelve 16 KB segments. The 64 KB boot segment runs from 0xF0000 to 0xFFFFF. Each segment has its own 2-bit attribute, and two attributes are packed into one byte, one per nibble.

Configuration bytes are written through a byte-wide port (offset, data, strobe). The routing answer is combinational from the access inputs and the stored bytes, so a new setting governs accesses starting one clock after the strobe edge.

Top module: `legacy_mem_router`

## Requirements
- R1: After reset the graphics control byte holds 0x02 and every attribute byte holds 0x00. Every access in 0xA0000 to 0xFFFFF then routes to the bus (route 2'b10), whatever the mode.
- R2: An address below 0xA0000 or above 0xFFFFF gives route 2'b00 (not legacy) and wr_block low.
- R3: The segment 0xF0000 to 0xFFFFF uses bits [5:4] of the byte at offset 0x59 as its attribute.
- R4: The 16 KB segment i (i = 0..11, base 0xC0000 + i*0x4000) uses the byte at offset 0x5A + (i>>1). It takes bits [1:0] when i is even and bits [5:4] when i is odd.
- R5: Attribute 3 routes both reads and writes to DRAM (route 2'b01) with wr_block low.
- R6: Attribute 1 routes reads to DRAM with wr_block low. It routes writes to DRAM with wr_block high, so the write must not change DRAM.
- R7: Attributes 0 and 2 route the access to the bus (route 2'b10) with wr_block low.
- R8: An access in 0xA0000 to 0xBFFFF routes to DRAM when bit 6 of the byte at offset 0x72 is set, or when bit 3 is set and acc_smm is high. Otherwise it routes to the bus. wr_block stays low in this region.
- R9: A write to offset 0x59..0x5F or 0x72 changes the route from the cycle after its strobe edge. Accesses in the strobe cycle itself still see the old setting.
- R10: A strobed write to any other offset changes no route.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_offset | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| acc_addr | input | ADDR_W (32) | Access physical address |
| acc_write | input | 1 | 1 = write access, 0 = read |
| acc_smm | input | 1 | Access is made in system management mode |
| route | output | 2 | 00 not legacy, 01 DRAM, 10 expansion bus |
| wr_block | output | 1 | Write must not modify DRAM (read-only segment) |

## Verification
The case that is hardest to reach from the ports is the graphics hole opened only by the mode-gated bit. It needs the control byte written with bit 3 set and bit 6 clear, then accesses to the hole with both values of acc_smm. A stale or mis-ordered setting also only shows when a write and an access land in the same cycle. The stimulus therefore writes random bytes to the whole offset range, including offsets that must be ignored, and checks random addresses, directions and modes against a model after each write. Directed sequences cover each combination of the two control bits, every nibble of every attribute byte, and an access placed in the strobe cycle of a write.

// File: rtl/lmw_pkg.sv
package lmw_pkg;
  typedef enum logic [1:0] {
    ROUTE_PASS = 2'b00,
    ROUTE_DRAM = 2'b01,
    ROUTE_BUS  = 2'b10
  } route_e;

  typedef enum logic [1:0] {
    REG_NONE  = 2'd0,
    REG_GFX   = 2'd1,
    REG_SEG16 = 2'd2,
    REG_SEG64 = 2'd3
  } region_e;

  localparam logic [1:0] ATTR_OFF  = 2'd0;
  localparam logic [1:0] ATTR_RO   = 2'd1;
  localparam logic [1:0] ATTR_WO   = 2'd2;
  localparam logic [1:0] ATTR_RW   = 2'd3;
endpackage

// File: rtl/lmw_cfg_regs.sv
module lmw_cfg_regs #(
  parameter int          NUM_ATTR  = 7,
  parameter logic [7:0]  ATTR_BASE = 8'h59,
  parameter logic [7:0]  GFX_OFS   = 8'h72,
  parameter logic [7:0]  GFX_RST   = 8'h02
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [7:0]               offset,
  input  logic [7:0]               wdata,
  output logic [NUM_ATTR-1:0][7:0] attr_q,
  output logic [7:0]               gfx_q
);
  logic [NUM_ATTR-1:0] hit;

  for (genvar b = 0; b < NUM_ATTR; b++) begin : g_attr
    localparam logic [7:0] MY_OFS = ATTR_BASE + 8'(b);
    assign hit[b] = wr_en && (offset == MY_OFS);

    always_ff @(posedge clk) begin
      if (rst)         attr_q[b] <= 8'h00;
      else if (hit[b]) attr_q[b] <= wdata;
    end

    assert_attr_load_R9: assert property (@(posedge clk) disable iff (rst)
      (wr_en && offset == MY_OFS) |=> attr_q[b] == $past(wdata));
  end

  always_ff @(posedge clk) begin
    if (rst)                            gfx_q <= GFX_RST;
    else if (wr_en && offset == GFX_OFS) gfx_q <= wdata;
  end

  assert_gfx_load_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && offset == GFX_OFS) |=> gfx_q == $past(wdata));

  assert_ignored_ofs_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && offset != GFX_OFS &&
     (offset < ATTR_BASE || offset >= ATTR_BASE + 8'(NUM_ATTR)))
    |=> ($stable(attr_q) && $stable(gfx_q)));

  assert_reset_gfx_R1: assert property (@(posedge clk)
    rst |=> gfx_q == GFX_RST);
endmodule

// File: rtl/lmw_window_decode.sv
module lmw_window_decode
  import lmw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [3:0]        seg_idx
);
  localparam logic [5:0] SEG16_FIRST = 6'h30;

  logic       low_meg;
  logic [3:0] blk64;
  logic [5:0] blk16;

  assign low_meg = (addr[ADDR_W-1:20] == '0);
  assign blk64   = addr[19:16];
  assign blk16   = addr[19:14];

  always_comb begin
    region  = REG_NONE;
    seg_idx = 4'd0;
    if (low_meg) begin
      if (blk64 == 4'hA || blk64 == 4'hB) begin
        region = REG_GFX;
      end else if (blk64 >= 4'hC && blk64 <= 4'hE) begin
        region  = REG_SEG16;
        seg_idx = 4'(blk16 - SEG16_FIRST);
      end else if (blk64 == 4'hF) begin
        region = REG_SEG64;
      end
    end
  end
endmodule

// File: rtl/lmw_attr_route.sv
module lmw_attr_route
  import lmw_pkg::*;
#(
  parameter int NUM_ATTR = 7,
  parameter int NUM_SEG  = 12,
  parameter int GFX_OPEN_BIT = 6,
  parameter int GFX_SMM_BIT  = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_ATTR-1:0][7:0] attr_q,
  input  logic [7:0]               gfx_q,
  input  region_e                  region,
  input  logic [3:0]               seg_idx,
  input  logic                     is_write,
  input  logic                     in_smm,
  output route_e                   route,
  output logic                     wr_block
);
  logic [NUM_SEG-1:0][1:0] seg_code;
  logic [1:0]              code;
  logic                    gfx_open;

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    localparam int BYTE = 1 + s / 2;
    if (s % 2 == 0) begin : g_lo
      assign seg_code[s] = attr_q[BYTE][1:0];
    end else begin : g_hi
      assign seg_code[s] = attr_q[BYTE][5:4];
    end
  end

  assign gfx_open = gfx_q[GFX_OPEN_BIT] || (gfx_q[GFX_SMM_BIT] && in_smm);

  always_comb begin
    code = ATTR_OFF;
    if (region == REG_SEG64)      code = attr_q[0][5:4];
    else if (region == REG_SEG16) code = seg_code[seg_idx];
  end

  always_comb begin
    route    = ROUTE_PASS;
    wr_block = 1'b0;
    unique case (region)
      REG_NONE: route = ROUTE_PASS;
      REG_GFX:  route = gfx_open ? ROUTE_DRAM : ROUTE_BUS;
      default: begin
        if (code == ATTR_RW) begin
          route = ROUTE_DRAM;
        end else if (code == ATTR_RO) begin
          route    = ROUTE_DRAM;
          wr_block = is_write;
        end else begin
          route = ROUTE_BUS;
        end
      end
    endcase
  end

  assert_seg_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    region == REG_SEG16 |-> seg_idx < 4'(NUM_SEG));

  assert_gfx_closed_R8: assert property (@(posedge clk) disable iff (rst)
    (region == REG_GFX && !gfx_q[GFX_OPEN_BIT] && !(gfx_q[GFX_SMM_BIT] && in_smm))
    |-> route == ROUTE_BUS);

  assert_gfx_no_block_R8: assert property (@(posedge clk) disable iff (rst)
    region == REG_GFX |-> !wr_block);
endmodule

// File: rtl/legacy_mem_router.sv
module legacy_mem_router
  import lmw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [7:0]        cfg_offset,
  input  logic [7:0]        cfg_wdata,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic              acc_smm,
  output logic [1:0]        route,
  output logic              wr_block
);
  localparam int NUM_ATTR = 7;
  localparam int NUM_SEG  = 2 * (NUM_ATTR - 1);

  logic [NUM_ATTR-1:0][7:0] attr_q;
  logic [7:0]               gfx_q;
  region_e                  region;
  logic [3:0]               seg_idx;
  route_e                   route_int;

  lmw_cfg_regs #(
    .NUM_ATTR (NUM_ATTR),
    .ATTR_BASE(8'h59),
    .GFX_OFS  (8'h72),
    .GFX_RST  (8'h02)
  ) u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr_en (cfg_wr_en),
    .offset(cfg_offset),
    .wdata (cfg_wdata),
    .attr_q(attr_q),
    .gfx_q (gfx_q)
  );

  lmw_window_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (acc_addr),
    .region (region),
    .seg_idx(seg_idx)
  );

  lmw_attr_route #(
    .NUM_ATTR(NUM_ATTR),
    .NUM_SEG (NUM_SEG)
  ) u_route (
    .clk     (clk),
    .rst     (rst),
    .attr_q  (attr_q),
    .gfx_q   (gfx_q),
    .region  (region),
    .seg_idx (seg_idx),
    .is_write(acc_write),
    .in_smm  (acc_smm),
    .route   (route_int),
    .wr_block(wr_block)
  );

  assign route = route_int;

  assert_outside_pass_R2: assert property (@(posedge clk) disable iff (rst)
    (acc_addr[ADDR_W-1:20] != '0 || acc_addr[19:16] < 4'hA)
    |-> (route == ROUTE_PASS && !wr_block));

  assert_block_needs_write_R6: assert property (@(posedge clk) disable iff (rst)
    wr_block |-> (acc_write && route == ROUTE_DRAM));

  assert_legal_route_R7: assert property (@(posedge clk) disable iff (rst)
    route != 2'b11);
endmodule

// File: tb/legacy_mem_router_tb.sv
module legacy_mem_router_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_offset = 8'h00;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [31:0] acc_addr = 32'h0;
  logic        acc_write = 1'b0;
  logic        acc_smm = 1'b0;
  logic [1:0]  route;
  logic        wr_block;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [7:0] m_attr [7];
  logic [7:0] m_gfx;

  always #5 clk = ~clk;

  legacy_mem_router u_dut (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_offset(cfg_offset),
    .cfg_wdata(cfg_wdata), .acc_addr(acc_addr), .acc_write(acc_write),
    .acc_smm(acc_smm), .route(route), .wr_block(wr_block)
  );

  // expected route/wr_block from the model bytes: {route, wr_block}
  function automatic logic [2:0] expect_of(logic [31:0] a, logic w, logic s);
    logic [1:0] c;
    int i;
    if (a < 32'hA0000 || a > 32'hFFFFF) return 3'b000;
    if (a < 32'hC0000) begin
      if (m_gfx[6] || (m_gfx[3] && s)) return 3'b010;
      return 3'b100;
    end
    if (a >= 32'hF0000) c = m_attr[0][5:4];
    else begin
      i = int'((a - 32'hC0000) >> 14);
      c = (i % 2 == 0) ? m_attr[1 + i/2][1:0] : m_attr[1 + i/2][5:4];
    end
    if (c == 2'd3) return 3'b010;
    if (c == 2'd1) return {2'b01, w};
    return 3'b100;
  endfunction

  function automatic string tag_of(logic [31:0] a);
    if (a < 32'hA0000 || a > 32'hFFFFF) return "R2";
    if (a < 32'hC0000) return "R8";
    if (a >= 32'hF0000) return "R3";
    return "R4";
  endfunction

  task automatic check(string tag, logic [2:0] exp);
    n_checks++;
    if ({route, wr_block} !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h wr=%0b smm=%0b actual route=%b blk=%b expected route=%b blk=%b",
               tag, acc_addr, acc_write, acc_smm, route, wr_block, exp[2:1], exp[0]);
    end
  endtask

  task automatic access(logic [31:0] a, logic w, logic s, string tag);
    @(negedge clk);
    acc_addr = a; acc_write = w; acc_smm = s;
    #1;
    check(tag, expect_of(a, w, s));
  endtask

  task automatic cfg_write(logic [7:0] ofs, logic [7:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_offset = ofs; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    if (ofs >= 8'h59 && ofs <= 8'h5F) m_attr[ofs - 8'h59] = d;
    else if (ofs == 8'h72) m_gfx = d;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h1F2E3D;
    void'($urandom(seed));
    for (int k = 0; k < 7; k++) m_attr[k] = 8'h00;
    m_gfx = 8'h02;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state, every region forwarded to bus
    access(32'h000A0000, 1'b0, 1'b1, "R1");
    access(32'h000BFFFF, 1'b1, 1'b0, "R1");
    access(32'h000C0000, 1'b0, 1'b0, "R1");
    access(32'h000EFFFF, 1'b1, 1'b0, "R1");
    access(32'h000F8000, 1'b0, 1'b0, "R1");

    // R2: outside the window
    access(32'h0009FFFF, 1'b1, 1'b0, "R2");
    access(32'h00100000, 1'b0, 1'b0, "R2");
    access(32'h800F0000, 1'b1, 1'b1, "R2");

    // R3 / R5 / R6 / R7 on the 64 KB segment, every code
    for (int c = 0; c < 4; c++) begin
      cfg_write(8'h59, 8'(c << 4) | 8'h03);
      access(32'h000F0000, 1'b0, 1'b0, c == 3 ? "R5" : (c == 1 ? "R6" : "R7"));
      access(32'h000FFFF0, 1'b1, 1'b0, c == 3 ? "R5" : (c == 1 ? "R6" : "R7"));
      access(32'h000F4000, 1'b0, 1'b0, "R3");
    end

    // R4: each 16 KB segment alone set to code 3, neighbours to code 1
    for (int s = 0; s < 12; s++) begin
      for (int b = 1; b < 7; b++) cfg_write(8'h59 + 8'(b), 8'h11);
      cfg_write(8'h5A + 8'(s / 2), (s % 2 == 0) ? 8'h13 : 8'h31);
      access(32'h000C0000 + 32'(s) * 32'h4000 + 32'h10, 1'b1, 1'b0, "R4");
      access(32'h000C3FFF + 32'(s) * 32'h4000, 1'b1, 1'b0, "R4");
    end

    // R8: every combination of the two control bits and mode
    for (int g = 0; g < 4; g++) begin
      cfg_write(8'h72, {1'b0, g[1], 2'b00, g[0], 3'b010});
      access(32'h000A8000, 1'b0, 1'b0, "R8");
      access(32'h000B0000, 1'b1, 1'b1, "R8");
    end

    // R9: access in the strobe cycle sees old value, next cycle sees new
    cfg_write(8'h72, 8'h00);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_offset = 8'h72; cfg_wdata = 8'h40;
    acc_addr = 32'h000A0000; acc_write = 1'b0; acc_smm = 1'b0;
    #1;
    check("R9", 3'b100);
    @(negedge clk);
    cfg_wr_en = 1'b0;
    m_gfx = 8'h40;
    #1;
    check("R9", 3'b010);

    // R10: writes to neighbouring and far offsets are ignored
    cfg_write(8'h59, 8'h30);
    cfg_write(8'h58, 8'h00);
    cfg_write(8'h60, 8'h00);
    cfg_write(8'h71, 8'h00);
    cfg_write(8'h73, 8'h00);
    access(32'h000F0000, 1'b1, 1'b0, "R10");
    access(32'h000A0000, 1'b0, 1'b0, "R10");

    // random mix
    for (int r = 0; r < 400; r++) begin
      logic [31:0] a;
      logic [7:0] ofs;
      if (($urandom % 3) == 0) begin
        case ($urandom % 4)
          0: ofs = 8'h72;
          1: ofs = 8'($urandom);
          default: ofs = 8'h59 + 8'($urandom % 7);
        endcase
        cfg_write(ofs, 8'($urandom));
      end
      if (($urandom % 8) == 0) a = $urandom;
      else a = 32'h00090000 + ($urandom % 32'h80000);
      access(a, 1'($urandom), 1'($urandom), tag_of(a));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule